// File: doc/BRIEF.md
# SPI Register-File Slave with Write Tracing

This block is a serial slave that gives an external controller access to a byte-wide, 256-entry register file held in the core. Each frame opens when the chip-select line goes low. The controller then sends a command byte and an address byte, most significant bit first. What follows depends on the command. A single write stores one data byte. A single read returns one byte. A burst read returns consecutive bytes for as long as chip select stays low.

The serial inputs are synchronised into the core clock. Every SPI event is handled as a one-cycle strobe on that clock. The core side is a plain register-file port:
- an address;
- a write strobe with its data;
- a read strobe with combinational read data.

The register file decides for itself which locations clear when they are read. In a burst, the next byte is fetched at the last bit of the current byte. The read strobe therefore marks the moment a clear-on-read location is emptied, even if the controller stops before that byte is shifted out.

Each completed write is copied into two trace registers: one holds the write address and one holds the data. The controller can read them back at two fixed addresses to confirm what arrived.

Top module: `spi_rf_slave`

## Requirements
- R1: A high level on the chip-select input ends the frame at once. An unfinished burst is abandoned, and the next frame decodes from its command byte.
- R2: The command byte and the address byte are taken from SDI on SCK rising edges, most significant bit first.
- R3: Command 0x03 (burst read) returns the byte at the start address first. Each further byte comes from the address plus one, wrapping from 0xFF to 0x00.
- R4: Read data leaves on SDO most significant bit first. The output enable is low throughout the command and address bytes and whenever no read data is being driven.
- R5: Command 0x01 (single write) stores the byte that follows the address byte into the register at that address.
- R6: Every completed write copies its address into the trace register read at address 0xFE, and its data into the trace register read at address 0xFF. Only the latest write is kept.
- R7: The read strobe for the next burst byte is issued at the last SCK rising edge of the current byte. A clear-on-read location fetched there is cleared even when chip select rises before any of its bits are shifted out.
- R8: A command other than 0x01, 0x02 or 0x03 keeps the output enable low for the whole frame, and writes neither the register file nor the trace registers.
- R9: A write frame that ends with fewer than 8 data bits leaves both the target register and the trace registers unchanged.
- R10: SDO changes only after SCK falling edges (SPI mode 0). The first data bit is already on SDO before the first SCK rising edge of the data phase.
- R11: Command 0x02 (single read) returns the byte at the address. The output enable drops after that byte's last SCK rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all serial lines are oversampled by it |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_sdi | input | 1 | Serial data into the slave |
| spi_sdo | output | 1 | Serial read data |
| spi_sdo_oe | output | 1 | Enable for the SDO pad driver; low means high impedance |
| rf_addr | output | 8 | Register-file address for the current access |
| rf_rd_en | output | 1 | One-cycle read strobe; the register file may clear the location on it |
| rf_rdata | input | 8 | Register-file read data for rf_addr, valid in the same cycle |
| rf_wr_en | output | 1 | One-cycle write strobe |
| rf_wdata | output | 8 | Register-file write data |

## Verification
The embedded properties assume that SCK is at least several core-clock periods wide in each phase. This lets every serial edge appear as a separate one-cycle strobe after the synchroniser. They also assume that SDI is settled before each SCK rising edge, and that chip select does not change in the same core cycle as an SCK edge. The bench respects all of this. It moves only one serial line at a time, on falling core-clock edges, and holds each SCK phase for eight core cycles. It also waits a full phase after lowering chip select before the first SCK edge, and after the last SCK edge before raising it.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] CMD_WRITE = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_READ  = 8'h02;
  localparam logic [BYTE_W-1:0] CMD_BURST = 8'h03;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADR,
    PH_WDATA,
    PH_RDATA,
    PH_HOLD
  } phase_e;

  // Reading commands fetch a byte once the address byte has arrived.
  function automatic logic cmd_is_read(input logic [BYTE_W-1:0] c);
    return (c == CMD_READ) || (c == CMD_BURST);
  endfunction

  // The burst address advances modulo the address space.
  function automatic logic [BYTE_W-1:0] addr_step(input logic [BYTE_W-1:0] a);
    return a + {{(BYTE_W-1){1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/spi_rf_shift.sv
module spi_rf_shift
  import spi_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_on,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_byte,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              sdo_bit
);

  logic [BYTE_W-2:0]    in_q;
  logic [BIT_CNT_W-1:0] cnt_q;
  logic [BYTE_W-1:0]    out_q;
  logic                 bit_q;

  // Named shift events, brought out for the checks below.
  logic in_shift_ev, out_shift_ev;
  assign in_shift_ev  = frame_on && sck_rise;
  assign out_shift_ev = frame_on && sck_fall && !load_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      cnt_q <= '0;
    end else if (!frame_on) begin
      in_q  <= '0;
      cnt_q <= '0;
    end else if (in_shift_ev) begin
      in_q  <= {in_q[BYTE_W-3:0], sdi};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      bit_q <= 1'b0;
    end else if (load_en) begin
      out_q <= load_byte;
    end else if (out_shift_ev) begin
      bit_q <= out_q[BYTE_W-1];
      out_q <= {out_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign rx_byte   = {in_q, sdi};
  assign byte_done = in_shift_ev && (cnt_q == BIT_CNT_W'(BYTE_W - 1));
  assign sdo_bit   = bit_q;

  assert_idle_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_on |=> (cnt_q == '0));

  assert_sdo_falling_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_shift_ev |=> $stable(bit_q));

endmodule

// File: rtl/spi_rf_ctrl.sv
module spi_rf_ctrl
  import spi_rf_pkg::*;
#(
  parameter logic [BYTE_W-1:0] TRACE_ADR_LOC = 8'hFE,
  parameter logic [BYTE_W-1:0] TRACE_DAT_LOC = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_on,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] rf_rdata,
  output logic [BYTE_W-1:0] rf_addr,
  output logic              rf_rd_en,
  output logic              rf_wr_en,
  output logic [BYTE_W-1:0] rf_wdata,
  output logic              load_en,
  output logic [BYTE_W-1:0] load_byte,
  output logic              sdo_oe
);

  phase_e            ph_q;
  logic [BYTE_W-1:0] cmd_q, adr_q, trc_adr_q, trc_dat_q;
  logic              oe_q;

  // Named events of the frame sequence.
  logic cmd_done, adr_done, wr_commit, fetch_first, fetch_next, fetch;
  logic [BYTE_W-1:0] fetch_addr;

  assign cmd_done    = byte_done && (ph_q == PH_CMD);
  assign adr_done    = byte_done && (ph_q == PH_ADR);
  assign wr_commit   = byte_done && (ph_q == PH_WDATA);
  assign fetch_first = adr_done && cmd_is_read(cmd_q);
  assign fetch_next  = byte_done && (ph_q == PH_RDATA) && (cmd_q == CMD_BURST);
  assign fetch       = fetch_first || fetch_next;
  assign fetch_addr  = fetch_first ? rx_byte : addr_step(adr_q);

  assign rf_addr  = fetch ? fetch_addr : adr_q;
  assign rf_rd_en = fetch;
  assign rf_wr_en = wr_commit;
  assign rf_wdata = rx_byte;
  assign load_en  = fetch;
  assign sdo_oe   = oe_q;

  always_comb begin
    if (fetch_addr == TRACE_ADR_LOC)      load_byte = trc_adr_q;
    else if (fetch_addr == TRACE_DAT_LOC) load_byte = trc_dat_q;
    else                                  load_byte = rf_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_CMD;
      cmd_q <= '0;
      adr_q <= '0;
      oe_q  <= 1'b0;
    end else if (!frame_on) begin
      ph_q <= PH_CMD;
      oe_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_CMD: if (cmd_done) begin
          cmd_q <= rx_byte;
          ph_q  <= PH_ADR;
        end
        PH_ADR: if (adr_done) begin
          adr_q <= rx_byte;
          if (cmd_q == CMD_WRITE) begin
            ph_q <= PH_WDATA;
          end else if (cmd_is_read(cmd_q)) begin
            ph_q <= PH_RDATA;
            oe_q <= 1'b1;
          end else begin
            ph_q <= PH_HOLD;
          end
        end
        PH_WDATA: if (wr_commit) ph_q <= PH_HOLD;
        PH_RDATA: if (byte_done) begin
          if (fetch_next) begin
            adr_q <= fetch_addr;
          end else begin
            ph_q <= PH_HOLD;
            oe_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trc_adr_q <= '0;
      trc_dat_q <= '0;
    end else if (wr_commit) begin
      trc_adr_q <= adr_q;
      trc_dat_q <= rx_byte;
    end
  end

  assert_write_cmd_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (cmd_q == CMD_WRITE));

  assert_rd_wr_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_wr_en && rf_rd_en));

  assert_fetch_read_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |-> cmd_is_read(cmd_q));

  assert_trace_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rf_wr_en) |-> (trc_adr_q == $past(rf_addr)) && (trc_dat_q == $past(rf_wdata)));

  assert_header_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_CMD) || (ph_q == PH_ADR)) |-> !oe_q);

  assert_fetch_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |=> (oe_q && (ph_q == PH_RDATA)));

endmodule

// File: rtl/spi_rf_slave.sv
module spi_rf_slave
  import spi_rf_pkg::*;
#(
  parameter int                SYNC_STAGES   = 2,
  parameter logic [BYTE_W-1:0] TRACE_ADR_LOC = 8'hFE,
  parameter logic [BYTE_W-1:0] TRACE_DAT_LOC = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic [BYTE_W-1:0] rf_addr,
  output logic              rf_rd_en,
  input  logic [BYTE_W-1:0] rf_rdata,
  output logic              rf_wr_en,
  output logic [BYTE_W-1:0] rf_wdata
);

  localparam int         N_LINES  = 3;
  localparam logic [2:0] LINE_RST = 3'b001;  // bit0 chip select idles high

  logic [N_LINES-1:0] line_raw, line_s;
  assign line_raw = {spi_sdi, spi_sck, spi_cs_n};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    spi_rf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LINE_RST[g])) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (line_raw[g]),
      .q     (line_s[g])
    );
  end

  logic cs_n_s, sck_s, sdi_s, sck_prev_q;
  assign cs_n_s = line_s[0];
  assign sck_s  = line_s[1];
  assign sdi_s  = line_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev_q <= 1'b0;
    else        sck_prev_q <= sck_s;
  end

  logic frame_on, sck_rise, sck_fall;
  assign frame_on = !cs_n_s;
  assign sck_rise = sck_s && !sck_prev_q;
  assign sck_fall = !sck_s && sck_prev_q;

  logic [BYTE_W-1:0] rx_byte, load_byte;
  logic              byte_done, load_en, sdo_bit;

  spi_rf_shift shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_on  (frame_on),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .sdi       (sdi_s),
    .load_en   (load_en),
    .load_byte (load_byte),
    .rx_byte   (rx_byte),
    .byte_done (byte_done),
    .sdo_bit   (sdo_bit)
  );

  spi_rf_ctrl #(.TRACE_ADR_LOC(TRACE_ADR_LOC), .TRACE_DAT_LOC(TRACE_DAT_LOC)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_on  (frame_on),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .rf_rdata  (rf_rdata),
    .rf_addr   (rf_addr),
    .rf_rd_en  (rf_rd_en),
    .rf_wr_en  (rf_wr_en),
    .rf_wdata  (rf_wdata),
    .load_en   (load_en),
    .load_byte (load_byte),
    .sdo_oe    (spi_sdo_oe)
  );

  assign spi_sdo = spi_sdo_oe && sdo_bit;

  assert_no_strobe_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_on |-> !(rf_wr_en || rf_rd_en));

endmodule

// File: tb/spi_rf_slave_tb.sv
module spi_rf_slave_tb_top;

  localparam int         HALF = 8;
  localparam logic [7:0] RC_LOC = 8'h40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic       sdo, sdo_oe, rf_rd_en, rf_wr_en;
  logic [7:0] rf_addr, rf_rdata, rf_wdata;

  always #2.5 clk = ~clk;

  spi_rf_slave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .rf_addr(rf_addr), .rf_rd_en(rf_rd_en),
    .rf_rdata(rf_rdata), .rf_wr_en(rf_wr_en), .rf_wdata(rf_wdata)
  );

  // Register-file model: seeded with addr^0x5A, one clear-on-read location.
  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    else if (rf_wr_en) mem[rf_addr] <= rf_wdata;
    else if (rf_rd_en && rf_addr == RC_LOC) mem[rf_addr] <= 8'h00;
  end
  assign rf_rdata = mem[rf_addr];

  int n_chk = 0, n_err = 0;
  logic oe_seen;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i >= 8 - nbits; i--) begin
      sdi = tx[i];
      wait_clk(HALF);
      rx[i] = sdo;
      oe_seen = oe_seen | sdo_oe;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_high();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic frame3(input logic [7:0] c, input logic [7:0] a, input logic [7:0] d,
                        output logic [7:0] rx, output logic hdr_oe, output logic dat_oe);
    logic [7:0] junk;
    cs_low();
    oe_seen = 1'b0;
    spi_byte(c, 8, junk);
    spi_byte(a, 8, junk);
    hdr_oe = oe_seen;
    oe_seen = 1'b0;
    spi_byte(d, 8, rx);
    dat_oe = oe_seen;
    cs_high();
  endtask

  task automatic single_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] rx;
    logic h, d;
    frame3(8'h02, a, 8'h00, rx, h, d);
    check(tag, rx, exp);
  endtask

  // Burst of n bytes; exp holds the expected bytes, first byte in the top lane.
  task automatic burst(input logic [7:0] a, input int n, input logic [31:0] exp, input string tag);
    logic [7:0] rx;
    cs_low();
    spi_byte(8'h03, 8, rx);
    spi_byte(a, 8, rx);
    for (int k = 0; k < n; k++) begin
      spi_byte(8'h00, 8, rx);
      check($sformatf("%s byte %0d", tag, k), rx, exp[31 - 8*k -: 8]);
    end
    cs_high();
  endtask

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] adr;
    logic [7:0] dat;
    logic [7:0] exp;
    logic       chk;
    logic       quiet;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{8'h01, 8'h10, 8'hA5, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 write
    '{8'h02, 8'h10, 8'h00, 8'hA5, 1'b1, 1'b0, 4'd5},  // R5 readback
    '{8'h02, 8'h11, 8'h00, 8'h4B, 1'b1, 1'b0, 4'd11}, // R11 seeded value 0x11^0x5A
    '{8'h01, 8'h80, 8'h3C, 8'h00, 1'b0, 1'b0, 4'd2},  // R2 address 0x80 not 0x01
    '{8'h02, 8'hFE, 8'h00, 8'h80, 1'b1, 1'b0, 4'd6},  // R6 trace address
    '{8'h02, 8'hFF, 8'h00, 8'h3C, 1'b1, 1'b0, 4'd6},  // R6 trace data
    '{8'h01, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 write 0x00
    '{8'h02, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b0, 4'd4},  // R4 MSB-first byte
    '{8'h07, 8'h00, 8'h11, 8'h00, 1'b0, 1'b1, 4'd8},  // R8 unknown command
    '{8'h02, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b0, 4'd8},  // R8 nothing written
    '{8'h00, 8'h20, 8'h33, 8'h00, 1'b0, 1'b1, 4'd8},  // R8 zero command
    '{8'h02, 8'hFE, 8'h00, 8'h00, 1'b1, 1'b0, 4'd8},  // R8 trace untouched
    '{8'h01, 8'h55, 8'h81, 8'h00, 1'b0, 1'b0, 4'd6}   // R6 new trace values
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [7:0] rx;
    logic h, d;
    wait_clk(5);
    // R1 reset state
    check("R1 reset oe", {7'd0, sdo_oe}, 8'h00);
    check("R1 reset strobes", {6'd0, rf_wr_en, rf_rd_en}, 8'h00);
    rst_n = 1'b1;
    wait_clk(5);

    for (int k = 0; k < NV; k++) begin
      frame3(VT[k].cmd, VT[k].adr, VT[k].dat, rx, h, d);
      check($sformatf("R4 header quiet vector %0d", k), {7'd0, h}, 8'h00);
      if (VT[k].quiet) check($sformatf("R%0d data quiet vector %0d", VT[k].req, k), {7'd0, d}, 8'h00);
      if (VT[k].chk)   check($sformatf("R%0d vector %0d", VT[k].req, k), rx, VT[k].exp);
    end

    // R10: first data bit present before first rising edge; R11 oe drops after byte
    cs_low();
    spi_byte(8'h02, 8, rx);
    spi_byte(8'h10, 8, rx);
    wait_clk(HALF);
    check("R10 oe before first rise", {7'd0, sdo_oe}, 8'h01);
    check("R10 MSB before first rise", {7'd0, sdo}, 8'h01);
    spi_byte(8'h00, 8, rx);
    check("R10 byte", rx, 8'hA5);
    wait_clk(HALF);
    check("R11 oe low after byte", {7'd0, sdo_oe}, 8'h00);
    cs_high();

    burst(8'h20, 4, 32'h7A7B7879, "R3 burst");
    burst(8'hFD, 4, 32'hA75581FF, "R3 wrap");
    // R7: burst stops after 0x3F; 0x40 was already fetched and is cleared
    burst(8'h3E, 2, 32'h64650000, "R7 burst");
    single_read(8'h40, 8'h00, "R7 cleared");
    single_read(8'h41, 8'h1B, "R7 neighbour");

    // R1: abort a burst in mid-byte, then a fresh frame decodes normally
    cs_low();
    spi_byte(8'h03, 8, rx);
    spi_byte(8'h12, 8, rx);
    spi_byte(8'h00, 8, rx);
    check("R1 burst first", rx, 8'h48);
    spi_byte(8'h00, 3, rx);
    cs_high();
    check("R1 oe after abort", {7'd0, sdo_oe}, 8'h00);
    single_read(8'h13, 8'h49, "R1 after abort");

    // R9: write frame cut after 4 data bits
    cs_low();
    spi_byte(8'h01, 8, rx);
    spi_byte(8'h30, 8, rx);
    spi_byte(8'hEE, 4, rx);
    cs_high();
    single_read(8'h30, 8'h6A, "R9 target");
    single_read(8'hFE, 8'h55, "R9 trace address");
    single_read(8'hFF, 8'h81, "R9 trace data");

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule